// File: doc/BRIEF.md
# Reference Clock Monitor with Holdover

This block watches a slow external reference clock from the domain of a fast local oscillator. It measures the reference frequency over windows of many reference periods and raises a status flag only while the reference is present and its measured frequency lies inside a tolerance window. It also owns the oscillator trim word. While the reference is trusted, the trim word follows updates from a frequency-comparison path outside the block. While the reference is missing or off frequency, the trim word stays frozen at its last tracked value.

The local oscillator always remains the clock source, so a reference failure changes nothing but the trim word. The controlled clock therefore has no switch-over and no glitch. Recovery needs no command. The block returns to tracking after a restored reference passes two measurement windows in a row. At the default parameters the reference runs at 8 kHz against an 18.432 MHz local clock (2304 cycles per period). A window is 256 periods and accepts ±147 counts, which is about ±250 ppm.

The control is a three-state machine. HOLD (frozen and not trusted) moves to QUALIFY on an in-range window. QUALIFY moves to TRACK on a second in-range window in a row. QUALIFY falls back to HOLD on a bad window or on loss. TRACK drops to HOLD on any bad window or on loss.

Top module: `refmon_holdover`

## Requirements
- R1: While reset is asserted and after it is released, `ref_ok` is 0 and `trim_out` equals mid-scale, 1 << (TRIM_W-1), which is 0x8000 for 16 bits.
- R2: The reference is taken through a two-flop synchroniser, and its rising edges are counted. A window covers WIN_PERIODS consecutive reference periods. It is in range when its length in local cycles lies within REF_DIV*WIN_PERIODS ± TOL_COUNTS, with both bounds included.
- R3: `ref_ok` rises only after two consecutive in-range windows, both after reset and after any fault.
- R4: While tracking, a window outside the tolerance drops `ref_ok` and enters holdover.
- R5: If LOSS_LIMIT local cycles pass with no reference edge, `ref_ok` drops without waiting for the window to finish.
- R6: While tracking, a cycle with `trim_vld` high loads `trim_in` into `trim_out` at the next clock edge.
- R7: While `ref_ok` is low, `trim_out` holds its value, and `trim_vld` has no effect.
- R8: Tracking resumes by itself once the reference returns at an in-range frequency.
- R9: A single gap between edges that is shorter than LOSS_LIMIT does not count as a loss. The window total alone decides the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | External reference clock, asynchronous to `clk` |
| trim_in | input | TRIM_W | Raw trim update from the comparison path |
| trim_vld | input | 1 | Qualifies `trim_in` for one cycle |
| ref_ok | output | 1 | High while the reference is trusted and tracked |
| trim_out | output | TRIM_W | Oscillator trim word |

## Verification
The bench shapes the reference as repeating four-interval patterns. This places window totals exactly on the tolerance bounds and one count past them. A design with an off-by-one window count or an exclusive bound would then lock or drop on the wrong side. A long gap inside a window that still totals nominal separates the loss timer from the frequency check. If the timer were ignored the status would stay high; if it fired early, tracking would never hold. The bench also watches `ref_ok` after a single good window and offers trim updates during holdover. A design that locks on one window, or that lets updates through while frozen, fails there.

// File: rtl/refmon_pkg.sv
package refmon_pkg;
    typedef enum logic [1:0] {
        ST_HOLD    = 2'd0,
        ST_QUALIFY = 2'd1,
        ST_TRACK   = 2'd2
    } refmon_state_e;
endpackage

// File: rtl/refmon_sync_edge.sv
module refmon_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [1:0] sync_q;
    logic       last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b00;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], async_in};
            last_q <= sync_q[1];
        end
    end

    assign rise = sync_q[1] & ~last_q;
endmodule

// File: rtl/refmon_meter.sv
module refmon_meter #(
    parameter int REF_DIV     = 2304,
    parameter int WIN_PERIODS = 256,
    parameter int TOL_COUNTS  = 147,
    parameter int LOSS_LIMIT  = 4608
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    output logic win_done,
    output logic win_good,
    output logic no_ref
);
    localparam int NOMINAL = REF_DIV * WIN_PERIODS;
    localparam int CW      = $clog2(WIN_PERIODS * LOSS_LIMIT + 1) + 1;
    localparam int GW      = $clog2(LOSS_LIMIT + 1);
    localparam int PW      = $clog2(WIN_PERIODS + 1);
    localparam logic [CW-1:0] LO_BOUND = CW'(NOMINAL - TOL_COUNTS);
    localparam logic [CW-1:0] HI_BOUND = CW'(NOMINAL + TOL_COUNTS);

    logic          armed_q;
    logic [CW-1:0] win_cnt_q;
    logic [PW-1:0] per_cnt_q;
    logic [GW-1:0] gap_q;
    logic [CW-1:0] span;
    logic          closing;

    assign span    = win_cnt_q + CW'(1);
    assign closing = rise && armed_q && (per_cnt_q == PW'(WIN_PERIODS - 1));
    assign no_ref  = (gap_q == GW'(LOSS_LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q   <= 1'b0;
            win_cnt_q <= '0;
            per_cnt_q <= '0;
            gap_q     <= '0;
            win_done  <= 1'b0;
            win_good  <= 1'b0;
        end else begin
            win_done <= 1'b0;
            if (rise) begin
                gap_q   <= '0;
                armed_q <= 1'b1;
                if (!armed_q || closing) begin
                    win_cnt_q <= '0;
                    per_cnt_q <= '0;
                end else begin
                    win_cnt_q <= span;
                    per_cnt_q <= per_cnt_q + PW'(1);
                end
                if (closing) begin
                    win_done <= 1'b1;
                    win_good <= (span >= LO_BOUND) && (span <= HI_BOUND);
                end
            end else begin
                if (!no_ref) begin
                    gap_q <= gap_q + GW'(1);
                end
                if (gap_q == GW'(LOSS_LIMIT - 1)) begin
                    armed_q   <= 1'b0;
                    per_cnt_q <= '0;
                    win_cnt_q <= '0;
                end else if (armed_q) begin
                    win_cnt_q <= span;
                end
            end
        end
    end
endmodule

// File: rtl/refmon_fsm.sv
module refmon_fsm
    import refmon_pkg::*;
#(
    parameter int TRIM_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_done,
    input  logic              win_good,
    input  logic              no_ref,
    input  logic [TRIM_W-1:0] trim_in,
    input  logic              trim_vld,
    output logic              ref_ok,
    output logic [TRIM_W-1:0] trim_out
);
    localparam logic [TRIM_W-1:0] TRIM_MID = TRIM_W'(1) << (TRIM_W - 1);

    refmon_state_e state_q, state_n;
    logic          fault, pass;

    assign fault = no_ref || (win_done && !win_good);
    assign pass  = !no_ref && win_done && win_good;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_HOLD:    if (pass)  state_n = ST_QUALIFY;
            ST_QUALIFY: if (fault) state_n = ST_HOLD;
                        else if (pass) state_n = ST_TRACK;
            ST_TRACK:   if (fault) state_n = ST_HOLD;
            default:    state_n = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_ok   <= 1'b0;
            trim_out <= TRIM_MID;
        end else begin
            ref_ok <= (state_n == ST_TRACK);
            if (state_q == ST_TRACK && state_n == ST_TRACK && trim_vld) begin
                trim_out <= trim_in;
            end
        end
    end
endmodule

// File: rtl/refmon_holdover.sv
module refmon_holdover #(
    parameter int REF_DIV     = 2304,
    parameter int WIN_PERIODS = 256,
    parameter int TOL_COUNTS  = 147,
    parameter int LOSS_LIMIT  = 2 * REF_DIV,
    parameter int TRIM_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_clk,
    input  logic [TRIM_W-1:0] trim_in,
    input  logic              trim_vld,
    output logic              ref_ok,
    output logic [TRIM_W-1:0] trim_out
);
    logic rise, win_done, win_good, no_ref;

    refmon_sync_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ref_clk),
        .rise     (rise)
    );

    refmon_meter #(
        .REF_DIV     (REF_DIV),
        .WIN_PERIODS (WIN_PERIODS),
        .TOL_COUNTS  (TOL_COUNTS),
        .LOSS_LIMIT  (LOSS_LIMIT)
    ) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (rise),
        .win_done (win_done),
        .win_good (win_good),
        .no_ref   (no_ref)
    );

    refmon_fsm #(
        .TRIM_W (TRIM_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_done (win_done),
        .win_good (win_good),
        .no_ref   (no_ref),
        .trim_in  (trim_in),
        .trim_vld (trim_vld),
        .ref_ok   (ref_ok),
        .trim_out (trim_out)
    );
endmodule

// File: rtl/refmon_holdover_chk.sv
module refmon_holdover_chk #(
    parameter int TRIM_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              win_done,
    input logic              win_good,
    input logic              no_ref,
    input logic [TRIM_W-1:0] trim_in,
    input logic              trim_vld,
    input logic              ref_ok,
    input logic [TRIM_W-1:0] trim_out
);
    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_status_r1: assert (!ref_ok);
        end
    end

    p_rise_after_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_ok) |-> $past(win_done && win_good && !no_ref));

    p_bad_window_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && !win_good) |=> !ref_ok);

    p_loss_drops_r5: assert property (@(posedge clk) disable iff (!rst_n)
        no_ref |=> !ref_ok);

    p_trim_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_ok && trim_vld && !no_ref && !(win_done && !win_good))
        |=> (trim_out == $past(trim_in)));

    p_trim_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_ok |=> $stable(trim_out));
endmodule

bind refmon_holdover refmon_holdover_chk #(.TRIM_W(TRIM_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_done (win_done),
    .win_good (win_good),
    .no_ref   (no_ref),
    .trim_in  (trim_in),
    .trim_vld (trim_vld),
    .ref_ok   (ref_ok),
    .trim_out (trim_out)
);

// File: tb/refmon_holdover_test.sv
module refmon_holdover_test;
    localparam int TW = 16;

    typedef struct {
        logic          ok;
        logic [TW-1:0] trim;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_clk = 1'b0;
    logic [TW-1:0] trim_in = '0;
    logic          trim_vld = 1'b0;
    logic          ref_ok;
    logic [TW-1:0] trim_out;

    int   n_run = 0;
    int   n_fail = 0;
    exp_t sb_q[$];

    int   per[4] = '{16, 16, 16, 16};
    bit   ref_en = 1'b0;
    int   gcnt = 0;
    int   gidx = 0;

    always #10 clk = ~clk;

    refmon_holdover #(
        .REF_DIV(16), .WIN_PERIODS(4), .TOL_COUNTS(2), .LOSS_LIMIT(32), .TRIM_W(TW)
    ) uut (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk),
        .trim_in(trim_in), .trim_vld(trim_vld),
        .ref_ok(ref_ok), .trim_out(trim_out)
    );

    initial begin
        forever begin
            @(negedge clk);
            if (ref_en) begin
                if (gcnt == 0) ref_clk = 1'b1;
                if (gcnt == per[gidx] / 2) ref_clk = 1'b0;
                gcnt++;
                if (gcnt >= per[gidx]) begin
                    gcnt = 0;
                    gidx = (gidx + 1) % 4;
                end
            end else begin
                ref_clk = 1'b0;
                gcnt = 0;
            end
        end
    end

    // scoreboard monitor
    initial begin
        forever begin
            wait (sb_q.size() != 0);
            begin
                exp_t e;
                e = sb_q.pop_front();
                n_run++;
                if (ref_ok !== e.ok || trim_out !== e.trim) begin
                    n_fail++;
                    $display("FAIL %s: ref_ok=%0b trim=%h expected ref_ok=%0b trim=%h",
                             e.tag, ref_ok, trim_out, e.ok, e.trim);
                end
            end
        end
    end

    task automatic expect_out(input logic ok, input logic [TW-1:0] tr, input string tag);
        exp_t e;
        e.ok = ok; e.trim = tr; e.tag = tag;
        sb_q.push_back(e);
        #1;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pattern(input int a, input int b, input int c, input int d);
        per[0] = a; per[1] = b; per[2] = c; per[3] = d;
    endtask

    task automatic push_trim(input logic [TW-1:0] v);
        trim_in = v; trim_vld = 1'b1;
        @(negedge clk);
        trim_vld = 1'b0;
        @(negedge clk);
    endtask

    task automatic span_check(input int n, input logic want, input logic [TW-1:0] tr,
                              input string tag);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (ref_ok !== want) bad++;
        end
        n_run++;
        if (bad != 0) begin
            n_fail++;
            $display("FAIL %s: ref_ok left %0b in %0d cycles, expected steady %0b",
                     tag, want, bad, want);
        end
        expect_out(want, tr, tag);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        cycles(3);
        expect_out(1'b0, 16'h8000, "R1 during reset");
        rst_n = 1'b1;
        cycles(2);
        expect_out(1'b0, 16'h8000, "R1 after reset");
        push_trim(16'h1234);
        expect_out(1'b0, 16'h8000, "R7 update ignored before lock");

        ref_en = 1'b1;
        cycles(96);
        expect_out(1'b0, 16'h8000, "R3 one window not enough");
        cycles(96);
        expect_out(1'b1, 16'h8000, "R2 R3 locked after two windows");
        push_trim(16'h4321);
        expect_out(1'b1, 16'h4321, "R6 trim load while tracking");

        ref_en = 1'b0;
        cycles(40);
        expect_out(1'b0, 16'h4321, "R5 loss drops status early");
        push_trim(16'h1111);
        expect_out(1'b0, 16'h4321, "R7 holdover freezes trim");

        ref_en = 1'b1;
        cycles(96);
        expect_out(1'b0, 16'h4321, "R3 one window after loss");
        cycles(96);
        expect_out(1'b1, 16'h4321, "R8 automatic resume");
        push_trim(16'h2222);
        expect_out(1'b1, 16'h2222, "R6 load after resume");

        pattern(17, 17, 17, 17);
        cycles(170);
        expect_out(1'b0, 16'h2222, "R4 slow reference drops");
        push_trim(16'h3333);
        expect_out(1'b0, 16'h2222, "R7 off-frequency freezes trim");

        pattern(16, 16, 17, 17);
        cycles(300);
        expect_out(1'b1, 16'h2222, "R2 upper bound +2 accepted");
        pattern(16, 17, 17, 17);
        cycles(170);
        expect_out(1'b0, 16'h2222, "R2 R4 +3 rejected");
        pattern(15, 15, 16, 16);
        cycles(300);
        expect_out(1'b1, 16'h2222, "R2 lower bound -2 accepted");
        pattern(15, 15, 15, 16);
        cycles(170);
        expect_out(1'b0, 16'h2222, "R2 R4 -3 rejected");

        pattern(31, 11, 11, 11);
        cycles(400);
        span_check(256, 1'b1, 16'h2222, "R9 short gap is not a loss");
        pattern(34, 10, 10, 10);
        cycles(80);
        span_check(256, 1'b0, 16'h2222, "R5 long gap in nominal window");

        pattern(16, 16, 16, 16);
        cycles(300);
        expect_out(1'b1, 16'h2222, "R8 final recovery");

        wait (sb_q.size() == 0);
        #1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule